// File: doc/BRIEF.md
# Banked Clock Divider Selector

This block turns one fast clock into two slower clocks with an even high and low time: one at half the source rate and one at a quarter of it. The two divided clocks feed twelve outputs grouped into four banks of three. A two-bit select splits the banks between the two rates like a thermometer. The lowest-numbered banks take the quarter-rate clock and the rest take the half-rate clock. The last bank always runs at half rate.

The divider source is normally the oscillator input. A bypass input switches the source to a separate reference clock so the outputs can be exercised without the oscillator. An asynchronous clear forces both divided clocks low and sets a known phase. An active-low output enable releases all twelve outputs to high impedance. The quarter-rate stage only advances on source edges where the half-rate clock goes high, so the banks switch together. Upstream logic can rely on a fixed edge relation between the banks.

Top module: `bank_clk_divsel`

## Requirements
- R1: The twelve outputs form four banks of three (bank 0 is `yout[2:0]`, bank 1 is `yout[5:3]`, bank 2 is `yout[8:6]`, bank 3 is `yout[11:9]`). All three outputs of a bank always carry the same value.
- R2: The half-rate clock toggles on every rising edge of the selected source clock. On the first rising edge after clear is released it goes high.
- R3: The quarter-rate clock changes only on source edges where the half-rate clock goes from low to high. It goes high on the first source edge after clear. It then stays high for two source periods and low for two.
- R4: The select `sel` is read as an unsigned number, with `sel[1]` as the most significant bit. Bank b carries the quarter-rate clock when b < `sel`, and the half-rate clock otherwise. So 0 gives all banks half rate, 1 gives bank 0 quarter rate, 2 gives banks 0 and 1 quarter rate, and 3 gives banks 0 to 2 quarter rate. Bank 3 always carries the half-rate clock.
- R5: While `oe_n` is high, all twelve outputs are high impedance. While `oe_n` is low, all twelve are driven.
- R6: While `test_byp` is high, the dividers are clocked by `ref_clk`, and edges of `osc_clk` have no effect on the outputs. Bank selection and enable work the same way as in normal mode.
- R7: While `clr` is high, both divided clocks are low. Clear takes effect at once, without waiting for a clock edge.
- R8: Every rising edge of the quarter-rate clock falls on a rising edge of the half-rate clock.
- R9: Both divided clocks change only on rising source edges, so their high and low times do not depend on the duty cycle of the source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Fast oscillator clock, used as the source in normal mode |
| ref_clk | input | 1 | Reference clock, used as the source in bypass mode |
| test_byp | input | 1 | High selects `ref_clk` as the divider source |
| clr | input | 1 | Asynchronous clear, active high, forces both divided clocks low |
| sel | input | 2 | Number of low banks that take the quarter-rate clock |
| oe_n | input | 1 | Active-low output enable; high puts all outputs in high impedance |
| yout | output | 12 | Four banks of three clock outputs |

## Verification
The assertions assume that `sel` changes only between source edges. They also assume that `test_byp` changes only while `clr` is high, so a switch of the source clock never produces a runt edge that counts. The stimulus follows both rules. It changes `test_byp` only inside a clear pulse, releases clear just after a falling source edge, and moves `sel` while clear is held. The bench pulls each output weakly high, so a released output reads as one while the dividers are held low.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;

   typedef enum logic {
      RATE_HALF    = 1'b0,
      RATE_QUARTER = 1'b1
   } rate_pick_e;

   // thermometer decode: bank index below the select count takes the slow clock
   function automatic rate_pick_e bank_rate(input int bank_idx, input int sel_val);
      return (bank_idx < sel_val) ? RATE_QUARTER : RATE_HALF;
   endfunction

endpackage

// File: rtl/bcd_src_mux.sv
`timescale 1ns/1ps
module bcd_src_mux #(
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic osc_clk,
   input  logic ref_clk,
   input  logic test_byp,
   output logic src_clk
);

   generate
      if (BYPASS_EN) begin : g_mux
         assign src_clk = test_byp ? ref_clk : osc_clk;
      end else begin : g_osc_only
         logic byp_unused;
         assign byp_unused = test_byp ^ ref_clk;
         assign src_clk    = osc_clk;
      end
   endgenerate

endmodule

// File: rtl/bcd_div_chain.sv
`timescale 1ns/1ps
module bcd_div_chain (
   input  logic src_clk,
   input  logic clr,
   output logic div_h,
   output logic div_q
);

   logic half_q;
   logic quart_q;

   // quarter stage steps only on the edge where the half stage rises,
   // which keeps both rising edges coincident
   always_ff @(posedge src_clk or posedge clr) begin
      if (clr) begin
         half_q  <= 1'b0;
         quart_q <= 1'b0;
      end else begin
         half_q <= ~half_q;
         if (!half_q) begin
            quart_q <= ~quart_q;
         end
      end
   end

   assign div_h = half_q;
   assign div_q = quart_q;

endmodule

// File: rtl/bcd_bank_map.sv
`timescale 1ns/1ps
module bcd_bank_map
   import bcd_pkg::*;
#(
   parameter int BANK_CNT = 4,
   parameter int SEL_W    = 2
) (
   input  logic [SEL_W-1:0]    sel,
   input  logic                div_h,
   input  logic                div_q,
   output logic [BANK_CNT-1:0] bank_clk
);

   localparam int MAX_SEL = (1 << SEL_W) - 1;

   genvar b;
   generate
      for (b = 0; b < BANK_CNT; b++) begin : g_bank
         if (b >= MAX_SEL) begin : g_fixed_half
            assign bank_clk[b] = div_h;
         end else begin : g_therm
            rate_pick_e pick;
            assign pick        = bank_rate(b, int'(sel));
            assign bank_clk[b] = (pick == RATE_QUARTER) ? div_q : div_h;
         end
      end
   endgenerate

endmodule

// File: rtl/bcd_out_fan.sv
`timescale 1ns/1ps
module bcd_out_fan #(
   parameter int BANK_CNT = 4,
   parameter int BANK_W   = 3
) (
   input  logic                         oe_n,
   input  logic [BANK_CNT-1:0]          bank_clk,
   output logic [BANK_CNT*BANK_W-1:0]   yout
);

   genvar b, i;
   generate
      for (b = 0; b < BANK_CNT; b++) begin : g_bank
         for (i = 0; i < BANK_W; i++) begin : g_pin
            assign yout[b*BANK_W+i] = oe_n ? 1'bz : bank_clk[b];
         end
      end
   endgenerate

endmodule

// File: rtl/bank_clk_divsel.sv
`timescale 1ns/1ps
module bank_clk_divsel #(
   parameter int BANK_CNT  = 4,
   parameter int BANK_W    = 3,
   parameter int SEL_W     = 2,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic                       osc_clk,
   input  logic                       ref_clk,
   input  logic                       test_byp,
   input  logic                       clr,
   input  logic [SEL_W-1:0]           sel,
   input  logic                       oe_n,
   output logic [BANK_CNT*BANK_W-1:0] yout
);

   localparam int OUT_W = BANK_CNT * BANK_W;

   generate
      if (BANK_CNT < (1 << SEL_W)) begin : g_bad_banks
         $error("bank_clk_divsel: select range leaves no bank fixed at half rate");
      end
      if (BANK_W < 1) begin : g_bad_width
         $error("bank_clk_divsel: banks need at least one output");
      end
      if (OUT_W > 4096) begin : g_bad_size
         $error("bank_clk_divsel: output count too large");
      end
   endgenerate

   logic                src_clk;
   logic                div_h;
   logic                div_q;
   logic [BANK_CNT-1:0] bank_clk;

   bcd_src_mux #(.BYPASS_EN(BYPASS_EN)) u_src (
      .osc_clk  (osc_clk),
      .ref_clk  (ref_clk),
      .test_byp (test_byp),
      .src_clk  (src_clk)
   );

   bcd_div_chain u_div (
      .src_clk (src_clk),
      .clr     (clr),
      .div_h   (div_h),
      .div_q   (div_q)
   );

   bcd_bank_map #(.BANK_CNT(BANK_CNT), .SEL_W(SEL_W)) u_map (
      .sel      (sel),
      .div_h    (div_h),
      .div_q    (div_q),
      .bank_clk (bank_clk)
   );

   bcd_out_fan #(.BANK_CNT(BANK_CNT), .BANK_W(BANK_W)) u_fan (
      .oe_n     (oe_n),
      .bank_clk (bank_clk),
      .yout     (yout)
   );

endmodule

// File: rtl/bcd_checker.sv
`timescale 1ns/1ps
module bcd_checker #(
   parameter int BANK_CNT = 4,
   parameter int BANK_W   = 3,
   parameter int SEL_W    = 2
) (
   input logic                       src_clk,
   input logic                       clr,
   input logic                       oe_n,
   input logic [SEL_W-1:0]           sel,
   input logic                       div_h,
   input logic                       div_q,
   input logic [BANK_CNT-1:0]        bank_clk,
   input logic [BANK_CNT*BANK_W-1:0] yout
);

   assert_half_toggle_R2: assert property (@(posedge src_clk) disable iff (clr)
      1'b1 |=> (div_h != $past(div_h)));

   assert_quarter_step_R3: assert property (@(posedge src_clk) disable iff (clr)
      (div_q != $past(div_q)) |-> $rose(div_h));

   assert_rise_align_R8: assert property (@(posedge src_clk) disable iff (clr)
      $rose(div_q) |-> $rose(div_h));

   assert_clr_low_R7: assert property (@(posedge src_clk)
      clr |-> (!div_h && !div_q));

   assert_driven_R5: assert property (@(posedge src_clk) disable iff (clr)
      !oe_n |-> (yout[BANK_W-1:0] == {BANK_W{bank_clk[0]}}));

   genvar b;
   generate
      for (b = 0; b < BANK_CNT; b++) begin : g_bank_chk
         assert_bank_same_R1: assert property (@(posedge src_clk) disable iff (clr)
            !oe_n |-> (yout[b*BANK_W +: BANK_W] == {BANK_W{yout[b*BANK_W]}}));

         assert_therm_sel_R4: assert property (@(posedge src_clk) disable iff (clr)
            !oe_n |-> (yout[b*BANK_W] == ((b < int'(sel)) ? div_q : div_h)));
      end
   endgenerate

endmodule

bind bank_clk_divsel bcd_checker #(
   .BANK_CNT (BANK_CNT),
   .BANK_W   (BANK_W),
   .SEL_W    (SEL_W)
) chk_i (
   .src_clk  (src_clk),
   .clr      (clr),
   .oe_n     (oe_n),
   .sel      (sel),
   .div_h    (div_h),
   .div_q    (div_q),
   .bank_clk (bank_clk),
   .yout     (yout)
);

// File: tb/bank_clk_divsel_tb_top.sv
`timescale 1ns/1ps
module bank_clk_divsel_tb_top;

   logic       osc_clk = 1'b0;
   logic       ref_clk = 1'b0;
   logic       test_byp = 1'b0;
   logic       clr = 1'b0;
   logic [1:0] sel = 2'd0;
   logic       oe_n = 1'b0;
   tri1 [11:0] y_bus;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 osc_clk = ~osc_clk;

   // reference clock with an uneven duty cycle: 4 ns high, 10 ns low
   always begin
      ref_clk = 1'b0;
      #10;
      ref_clk = 1'b1;
      #4;
   end

   bank_clk_divsel dut_i (
      .osc_clk  (osc_clk),
      .ref_clk  (ref_clk),
      .test_byp (test_byp),
      .clr      (clr),
      .sel      (sel),
      .oe_n     (oe_n),
      .yout     (y_bus)
   );

   task automatic chk(input bit ok, input string req, input logic [11:0] act,
                      input logic [11:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [11:0] expect_vec(input int k, input int s);
      logic [11:0] v;
      logic h;
      logic q;
      h = logic'(k % 2);
      q = logic'(((k + 1) / 2) % 2);
      for (int b = 0; b < 4; b++) begin
         for (int i = 0; i < 3; i++) begin
            v[b*3+i] = (b < s) ? q : h;
         end
      end
      return v;
   endfunction

   task automatic src_edge(input bit byp);
      if (byp) @(posedge ref_clk);
      else     @(posedge osc_clk);
   endtask

   task automatic start_run(input int s, input bit byp);
      clr = 1'b1;
      #1;
      test_byp = byp;
      sel      = 2'(s);
      #20;
      if (byp) @(negedge ref_clk);
      else     @(negedge osc_clk);
      #1;
      clr = 1'b0;
   endtask

   // R5 and R7: release and drive while held in clear
   task automatic t_reset_oe();
      clr  = 1'b1;
      oe_n = 1'b1;
      #3;
      chk(y_bus === 12'hFFF, "R5 released outputs", y_bus, 12'hFFF);
      oe_n = 1'b0;
      #3;
      chk(y_bus === 12'h000, "R5 R7 driven low in clear", y_bus, 12'h000);
   endtask

   // R1 R2 R3 R4: sequence for each select value in normal mode
   task automatic t_sel_seq(input int s);
      start_run(s, 1'b0);
      for (int k = 1; k <= 8; k++) begin
         src_edge(1'b0);
         #1;
         chk(y_bus === expect_vec(k, s), $sformatf("R1 R2 R3 R4 sel=%0d k=%0d", s, k),
             y_bus, expect_vec(k, s));
      end
   endtask

   // R6 R9: bypass source with uneven duty, also sampled mid low phase
   task automatic t_bypass(input int s);
      start_run(s, 1'b1);
      for (int k = 1; k <= 6; k++) begin
         src_edge(1'b1);
         #1;
         chk(y_bus === expect_vec(k, s), $sformatf("R6 sel=%0d k=%0d", s, k),
             y_bus, expect_vec(k, s));
         @(negedge ref_clk);
         #6;
         chk(y_bus === expect_vec(k, s), $sformatf("R9 R6 hold sel=%0d k=%0d", s, k),
             y_bus, expect_vec(k, s));
      end
      clr = 1'b1;
      #1;
      test_byp = 1'b0;
   endtask

   // R7: asynchronous clear mid-cycle; R8: both rise on first edge after
   task automatic t_async_clr();
      start_run(2, 1'b0);
      for (int k = 1; k <= 3; k++) src_edge(1'b0);
      #0.5;
      clr = 1'b1;
      #0.5;
      chk(y_bus === 12'h000, "R7 immediate clear", y_bus, 12'h000);
      src_edge(1'b0);
      #1;
      chk(y_bus === 12'h000, "R7 held in clear", y_bus, 12'h000);
      @(negedge osc_clk);
      #1;
      clr = 1'b0;
      src_edge(1'b0);
      #1;
      chk(y_bus === 12'hFFF, "R8 both rise together", y_bus, 12'hFFF);
   endtask

   // R5 while running: release, then drive again with the expected phase
   task automatic t_oe_running();
      start_run(3, 1'b0);
      src_edge(1'b0);
      src_edge(1'b0);
      #1;
      oe_n = 1'b1;
      #0.5;
      chk(y_bus === 12'hFFF, "R5 released while running", y_bus, 12'hFFF);
      oe_n = 1'b0;
      #0.5;
      chk(y_bus === expect_vec(2, 3), "R5 driven again", y_bus, expect_vec(2, 3));
   endtask

   initial begin
      #1;
      clr = 1'b1;
      t_reset_oe();
      for (int s = 0; s < 4; s++) t_sel_seq(s);
      t_bypass(1);
      t_bypass(3);
      t_async_clr();
      t_oe_running();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule